// File: doc/BRIEF.md
# Program Sequencer with Hardware Loop and Call Stacks

This block decides, every clock cycle, which program address is fetched next. It takes one-cycle control strobes from an instruction decoder (jump, call, return, loop start, repeat, halt) together with the operands that go with them: a target address, a loop end address and a count. From these it updates the program counter. It keeps two hardware stacks. A four-level loop stack holds the start address, end address and remaining count of each active loop. A fifteen-entry return stack is shared by subroutine calls and interrupt entry.

Ten interrupt request lines are latched into a pending register. Each line has its own enable bit. When enabled requests are pending, the lowest-numbered one preempts the current instruction. The address of that instruction is pushed as the return point, and the program counter moves to that source's vector. A halt strobe stops fetching and raises a low-power indicator until an enabled interrupt is pending. Fetching then resumes only after a fixed recovery delay.

The counter is a registered output. The strobes apply to the instruction whose address is on `pc` in the same cycle.

Top module: `seq_top`

## Requirements
- R1: In a running cycle with no strobe, no interrupt, no loop end match and no repeat hold, `pc` advances by exactly one at the next edge.
- R2: A jump strobe loads `tgt_addr` into `pc`. When several strobes arrive together, the order of precedence is interrupt entry, jump, call, return, loop, repeat, halt, and only the first one acts.
- R3: A call loads `tgt_addr` and pushes `pc+1`. A return loads the most recently pushed address. The return stack holds 15 entries.
- R4: A loop strobe pushes start `pc+1`, end `end_addr` and `count`, then continues at `pc+1`. When `pc` equals the top loop's end and no strobe is present: a count above one is decremented and `pc` goes to the start; a count of one or zero pops the level and `pc` falls through to `pc+1`. Four levels nest.
- R5: A repeat strobe with count N holds the following instruction's address for max(N,1) cycles, then advances. It uses no loop stack level. Interrupts wait until the last repetition.
- R6: A push onto a full stack or a pop from an empty one leaves that stack unchanged. It sets `stk_ovf` or `stk_udf` respectively, and the flag stays set until reset. A return on an empty stack continues at `pc+1`.
- R7: Requests are latched as pending on the edge where they are seen. While running, `irq_ack` is high in every cycle where an enabled source is pending. `irq_id` then names the lowest-numbered enabled pending source. External sources are 0–3 and internal sources are 4–9. At the next edge, `pc` becomes `IRQ_BASE + 4*irq_id`, the preempted address is pushed, and that source's pending bit clears.
- R8: A pending source whose enable bit is low is never acknowledged. It stays pending and is taken once enabled.
- R9: After a halt strobe, `pc` moves to the next address and then stays there. `sleep` is high and `fetch_en` is low until an enabled source is pending.
- R10: After `sleep` falls, `fetch_en` stays low for exactly `WAKE_CYC` cycles (default 4) before rising.
- R11: Reset gives `pc` = 0, empty stacks, no pending requests, cleared flags, `fetch_en` high and `sleep` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_jump | input | 1 | Jump strobe |
| op_call | input | 1 | Subroutine call strobe |
| op_ret | input | 1 | Return strobe |
| op_loop | input | 1 | Loop start strobe |
| op_rep | input | 1 | Single-instruction repeat strobe |
| op_halt | input | 1 | Halt strobe |
| tgt_addr | input | PC_W | Jump or call target |
| end_addr | input | PC_W | Last address of a loop body |
| count | input | CNT_W | Loop or repeat count |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-source enable bits |
| pc | output | PC_W | Program counter |
| fetch_en | output | 1 | Fetch enable |
| sleep | output | 1 | Low-power halt indicator |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| stk_udf | output | 1 | Sticky stack underflow flag |
| irq_ack | output | 1 | Interrupt taken this cycle |
| irq_id | output | $clog2(N_IRQ) | Number of the source being taken |

## Verification
A vector table runs a straight program from reset through a jump, a call and return pair, a three-pass loop and a three-cycle repeat. This separates plain increment from each redirect, and it shows that decrement and exit happen at the loop end, not one pass early or late. Directed sequences nest two loops that share addresses, to show that the inner level is popped before the outer one is consulted. They also fill each stack to its limit, then one entry past it, and unwind it fully, so that overflow is shown to leave the stored entries intact. Interrupt tests raise a disabled source together with two enabled ones at once, along with a competing jump strobe, to separate priority, masking and preemption. A halt sequence counts the cycles between the wake request and the resumption of fetch.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAKE} seq_state_e;

  typedef enum logic [2:0] {
    PCS_HOLD, PCS_INC, PCS_TGT, PCS_RET, PCS_LOOP, PCS_VEC
  } pc_sel_e;
endpackage

// File: rtl/seq_lifo.sv
module seq_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         ovf_evt,
  output logic         udf_evt
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;
  logic          full;
  logic [AW-1:0] idx_top;
  logic [AW-1:0] idx_new;

  assign full    = (ptr == PW'(DEPTH));
  assign empty   = (ptr == '0);
  assign idx_top = AW'(ptr - PW'(1));
  assign idx_new = AW'(ptr);
  assign top     = empty ? '0 : mem[idx_top];
  assign ovf_evt = push && full;
  assign udf_evt = pop && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (push && !full) begin
      ptr <= ptr + PW'(1);
    end else if (pop && !empty) begin
      ptr <= ptr - PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[idx_new] <= din;
    end else if (upd && !empty) begin
      mem[idx_top] <= upd_val;
    end
  end
endmodule

// File: rtl/seq_irq_pick.sv
module seq_irq_pick #(
  parameter int N  = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] id
);
  always_comb begin
    any = |req;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = IW'(i);
    end
  end
endmodule

// File: rtl/seq_top.sv
module seq_top #(
  parameter int PC_W       = 16,
  parameter int CNT_W      = 16,
  parameter int LOOP_DEPTH = 4,
  parameter int CALL_DEPTH = 15,
  parameter int N_IRQ      = 10,
  parameter int WAKE_CYC   = 4,
  parameter logic [PC_W-1:0] IRQ_BASE = 'h40,
  localparam int IW   = $clog2(N_IRQ),
  localparam int WW   = $clog2(WAKE_CYC + 1),
  localparam int LE_W = 2 * PC_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_jump,
  input  logic              op_call,
  input  logic              op_ret,
  input  logic              op_loop,
  input  logic              op_rep,
  input  logic              op_halt,
  input  logic [PC_W-1:0]   tgt_addr,
  input  logic [PC_W-1:0]   end_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  output logic [PC_W-1:0]   pc,
  output logic              fetch_en,
  output logic              sleep,
  output logic              stk_ovf,
  output logic              stk_udf,
  output logic              irq_ack,
  output logic [IW-1:0]     irq_id
);
  import seq_pkg::*;

  function automatic logic [PC_W-1:0] vec_of(input logic [IW-1:0] id);
    return IRQ_BASE + (PC_W'(id) << 2);
  endfunction

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] a);
    return a + PC_W'(1);
  endfunction

  function automatic logic cnt_again(input logic [CNT_W-1:0] c);
    return c > CNT_W'(1);
  endfunction

  seq_state_e        state;
  logic [WW-1:0]     wcnt;
  logic [CNT_W-1:0]  rep_left;
  logic [N_IRQ-1:0]  pend;
  logic [N_IRQ-1:0]  pend_en;
  logic [N_IRQ-1:0]  ack_mask;
  logic              irq_any;
  logic [IW-1:0]     pick_id;

  // Named internal events, also used by the checker
  logic running, rep_hold, take_irq, active, any_op;
  logic do_jump, do_call, do_ret, do_loop, do_rep, do_halt;
  logic loop_hit, loop_back, loop_exit;
  pc_sel_e pc_sel;
  logic [PC_W-1:0] pc_nx;

  // Return stack
  logic [PC_W-1:0] cs_top;
  logic            cs_empty, cs_ovf, cs_udf;
  // Loop stack
  logic [LE_W-1:0] lp_top;
  logic            lp_empty, lp_ovf, lp_udf;
  logic [PC_W-1:0]  lp_start, lp_end;
  logic [CNT_W-1:0] lp_cnt;

  assign lp_start = lp_top[LE_W-1 -: PC_W];
  assign lp_end   = lp_top[CNT_W +: PC_W];
  assign lp_cnt   = lp_top[CNT_W-1:0];

  assign pend_en = pend & irq_en;

  seq_irq_pick #(.N(N_IRQ)) u_pick (
    .req (pend_en),
    .any (irq_any),
    .id  (pick_id)
  );

  assign running  = (state == ST_RUN);
  assign rep_hold = running && (rep_left > CNT_W'(1));
  assign take_irq = running && !rep_hold && irq_any;
  assign active   = running && !rep_hold && !take_irq;
  assign any_op   = op_jump | op_call | op_ret | op_loop | op_rep | op_halt;

  assign do_jump = active && op_jump;
  assign do_call = active && !op_jump && op_call;
  assign do_ret  = active && !op_jump && !op_call && op_ret;
  assign do_loop = active && !op_jump && !op_call && !op_ret && op_loop;
  assign do_rep  = active && !op_jump && !op_call && !op_ret && !op_loop && op_rep;
  assign do_halt = active && !op_jump && !op_call && !op_ret && !op_loop && !op_rep && op_halt;

  assign loop_hit  = active && !any_op && !lp_empty && (pc == lp_end);
  assign loop_back = loop_hit && cnt_again(lp_cnt);
  assign loop_exit = loop_hit && !cnt_again(lp_cnt);

  seq_lifo #(.W(PC_W), .DEPTH(CALL_DEPTH)) u_call_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take_irq || do_call),
    .pop     (do_ret),
    .upd     (1'b0),
    .din     (take_irq ? pc : pc_step(pc)),
    .upd_val ('0),
    .top     (cs_top),
    .empty   (cs_empty),
    .ovf_evt (cs_ovf),
    .udf_evt (cs_udf)
  );

  seq_lifo #(.W(LE_W), .DEPTH(LOOP_DEPTH)) u_loop_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (do_loop),
    .pop     (loop_exit),
    .upd     (loop_back),
    .din     ({pc_step(pc), end_addr, count}),
    .upd_val ({lp_start, lp_end, lp_cnt - CNT_W'(1)}),
    .top     (lp_top),
    .empty   (lp_empty),
    .ovf_evt (lp_ovf),
    .udf_evt (lp_udf)
  );

  always_comb begin
    if (take_irq)                        pc_sel = PCS_VEC;
    else if (!active)                    pc_sel = PCS_HOLD;
    else if (do_jump || do_call)         pc_sel = PCS_TGT;
    else if (do_ret && !cs_empty)        pc_sel = PCS_RET;
    else if (loop_back)                  pc_sel = PCS_LOOP;
    else                                 pc_sel = PCS_INC;
  end

  always_comb begin
    unique case (pc_sel)
      PCS_VEC:  pc_nx = vec_of(pick_id);
      PCS_TGT:  pc_nx = tgt_addr;
      PCS_RET:  pc_nx = cs_top;
      PCS_LOOP: pc_nx = lp_start;
      PCS_INC:  pc_nx = pc_step(pc);
      default:  pc_nx = pc;
    endcase
  end

  assign ack_mask = take_irq ? (N_IRQ'(1) << pick_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      state    <= ST_RUN;
      wcnt     <= '0;
      rep_left <= '0;
      pend     <= '0;
      stk_ovf  <= 1'b0;
      stk_udf  <= 1'b0;
    end else begin
      pc      <= pc_nx;
      pend    <= (pend & ~ack_mask) | irq_req;
      stk_ovf <= stk_ovf | cs_ovf | lp_ovf;
      stk_udf <= stk_udf | cs_udf | lp_udf;

      if (do_rep)                               rep_left <= count;
      else if (running && rep_left != '0)       rep_left <= rep_left - CNT_W'(1);

      unique case (state)
        ST_RUN:   if (do_halt) state <= ST_SLEEP;
        ST_SLEEP: if (irq_any) begin
                    state <= ST_WAKE;
                    wcnt  <= WW'(WAKE_CYC - 1);
                  end
        ST_WAKE:  if (wcnt == '0) state <= ST_RUN;
                  else            wcnt  <= wcnt - WW'(1);
        default:  state <= ST_RUN;
      endcase
    end
  end

  assign fetch_en = running;
  assign sleep    = (state == ST_SLEEP);
  assign irq_ack  = take_irq;
  assign irq_id   = pick_id;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int PC_W     = 16,
  parameter int N_IRQ    = 10,
  parameter int WAKE_CYC = 4,
  localparam int IW      = $clog2(N_IRQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  pc,
  input logic             fetch_en,
  input logic             sleep,
  input logic             stk_ovf,
  input logic             stk_udf,
  input logic             irq_ack,
  input logic [IW-1:0]    irq_id,
  input logic [N_IRQ-1:0] irq_en,
  input logic [N_IRQ-1:0] pend,
  input logic             any_op,
  input logic             loop_hit,
  input logic             rep_hold,
  input logic             loop_back,
  input logic [PC_W-1:0]  lp_start
);
  logic [15:0] wk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wk <= '0;
    else if (sleep || fetch_en) wk <= '0;
    else if (wk != '1)         wk <= wk + 16'd1;
  end

  assert_plain_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !irq_ack && !any_op && !loop_hit && !rep_hold) |=> pc == $past(pc) + PC_W'(1));

  assert_loop_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back |=> pc == $past(lp_start));

  assert_rep_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_hold |=> $stable(pc));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_udf |=> stk_udf);

  assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ((pend & irq_en) & ((N_IRQ'(1) << irq_id) - N_IRQ'(1))) == '0);

  assert_masked_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> irq_en[irq_id]);

  assert_sleep_no_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !fetch_en);

  assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> $past(|(pend & irq_en)));

  assert_wake_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_en) |-> wk == 16'(WAKE_CYC));
endmodule

bind seq_top seq_chk #(.PC_W(PC_W), .N_IRQ(N_IRQ), .WAKE_CYC(WAKE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc        (pc),
  .fetch_en  (fetch_en),
  .sleep     (sleep),
  .stk_ovf   (stk_ovf),
  .stk_udf   (stk_udf),
  .irq_ack   (irq_ack),
  .irq_id    (irq_id),
  .irq_en    (irq_en),
  .pend      (pend),
  .any_op    (any_op),
  .loop_hit  (loop_hit),
  .rep_hold  (rep_hold),
  .loop_back (loop_back),
  .lp_start  (lp_start)
);

// File: tb/sim_seq_top.sv
module sim_seq_top;
  localparam int PC_W = 16;
  localparam int CNT_W = 16;
  localparam int N_IRQ = 10;

  localparam logic [2:0] OP_NONE = 3'd0, OP_JMP = 3'd1, OP_CALL = 3'd2, OP_RET = 3'd3,
                         OP_LOOP = 3'd4, OP_REP = 3'd5, OP_HALT = 3'd6;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [15:0] tgt;
    logic [15:0] lend;
    logic [15:0] cnt;
    logic [15:0] exp_pc;
  } row_t;

  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    '{4'd1, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd1},   // R1
    '{4'd1, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd2},   // R1
    '{4'd2, OP_JMP,  16'd10, 16'd0,  16'd0, 16'd10},  // R2
    '{4'd3, OP_CALL, 16'd20, 16'd0,  16'd0, 16'd20},  // R3 pushes 11
    '{4'd1, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd21},
    '{4'd3, OP_RET,  16'd0,  16'd0,  16'd0, 16'd11},  // R3
    '{4'd4, OP_LOOP, 16'd0,  16'd13, 16'd3, 16'd12},  // R4 start 12
    '{4'd4, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd13},
    '{4'd4, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd12},  // 3 -> 2
    '{4'd4, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd13},
    '{4'd4, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd12},  // 2 -> 1
    '{4'd4, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd13},
    '{4'd4, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd14},  // exit
    '{4'd5, OP_REP,  16'd0,  16'd0,  16'd3, 16'd15},  // R5
    '{4'd5, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd15},
    '{4'd5, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd15},
    '{4'd5, OP_NONE, 16'd0,  16'd0,  16'd0, 16'd16},
    '{4'd2, OP_JMP,  16'd30, 16'd0,  16'd0, 16'd30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_jump = 0, op_call = 0, op_ret = 0, op_loop = 0, op_rep = 0, op_halt = 0;
  logic [PC_W-1:0] tgt_addr = '0, end_addr = '0;
  logic [CNT_W-1:0] count = '0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic [PC_W-1:0] pc;
  logic fetch_en, sleep, stk_ovf, stk_udf, irq_ack;
  logic [3:0] irq_id;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  seq_top u0 (
    .clk(clk), .rst_n(rst_n), .op_jump(op_jump), .op_call(op_call), .op_ret(op_ret),
    .op_loop(op_loop), .op_rep(op_rep), .op_halt(op_halt), .tgt_addr(tgt_addr),
    .end_addr(end_addr), .count(count), .irq_req(irq_req), .irq_en(irq_en),
    .pc(pc), .fetch_en(fetch_en), .sleep(sleep), .stk_ovf(stk_ovf), .stk_udf(stk_udf),
    .irq_ack(irq_ack), .irq_id(irq_id)
  );

  function automatic logic [15:0] vec(input int id);
    return 16'h0040 + 16'(id * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_req = '0;
    irq_en = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [2:0] op, input logic [15:0] tgt,
                      input logic [15:0] lend, input logic [15:0] cnt);
    op_jump = (op == OP_JMP);
    op_call = (op == OP_CALL);
    op_ret  = (op == OP_RET);
    op_loop = (op == OP_LOOP);
    op_rep  = (op == OP_REP);
    op_halt = (op == OP_HALT);
    tgt_addr = tgt;
    end_addr = lend;
    count = cnt;
    @(posedge clk);
    @(negedge clk);
    {op_jump, op_call, op_ret, op_loop, op_rep, op_halt} = '0;
    irq_req = '0;
  endtask

  task automatic idle();
    step(OP_NONE, 16'd0, 16'd0, 16'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 pc", pc, 0);
    chk("R11 fetch_en", fetch_en, 1);
    chk("R11 sleep", sleep, 0);
    chk("R11 ovf", stk_ovf, 0);
    chk("R11 udf", stk_udf, 0);
    chk("R11 ack", irq_ack, 0);

    // Vector walk: R1..R5
    for (int i = 0; i < NROW; i++) begin
      step(TBL[i].op, TBL[i].tgt, TBL[i].lend, TBL[i].cnt);
      chk($sformatf("R%0d row %0d pc", TBL[i].req, i), pc, TBL[i].exp_pc);
    end
    chk("R6 no flag after clean run", {stk_ovf, stk_udf}, 0);

    // R4 nested loops sharing addresses
    do_reset();
    step(OP_LOOP, 0, 16'd3, 16'd2); chk("R4 nest a", pc, 1);
    step(OP_LOOP, 0, 16'd2, 16'd2); chk("R4 nest b", pc, 2);
    idle(); chk("R4 inner back", pc, 2);
    idle(); chk("R4 inner exit", pc, 3);
    idle(); chk("R4 outer back", pc, 1);
    idle(); chk("R4 outer body", pc, 2);
    idle(); chk("R4 inner gone", pc, 3);
    idle(); chk("R4 outer exit", pc, 4);

    // R5 repeat with count zero executes once
    do_reset();
    step(OP_REP, 0, 0, 16'd0); chk("R5 rep0 a", pc, 1);
    idle(); chk("R5 rep0 b", pc, 2);

    // R6 return on empty stack
    do_reset();
    step(OP_RET, 0, 0, 0);
    chk("R6 udf on empty ret", stk_udf, 1);
    chk("R6 empty ret falls through", pc, 1);
    chk("R6 ovf untouched", stk_ovf, 0);

    // R3/R6 return stack depth 15
    do_reset();
    for (int i = 0; i < 15; i++) step(OP_CALL, 16'd100, 0, 0);
    chk("R3 15 calls no ovf", stk_ovf, 0);
    step(OP_CALL, 16'd100, 0, 0);
    chk("R6 16th call ovf", stk_ovf, 1);
    for (int i = 0; i < 14; i++) begin
      step(OP_RET, 0, 0, 0);
      chk("R3 ret inner", pc, 101);
    end
    step(OP_RET, 0, 0, 0);
    chk("R6 bottom intact", pc, 1);
    chk("R6 no udf yet", stk_udf, 0);
    step(OP_RET, 0, 0, 0);
    chk("R6 udf after 16th ret", stk_udf, 1);

    // R4/R6 loop stack depth 4
    do_reset();
    for (int i = 0; i < 4; i++) step(OP_LOOP, 0, 16'd500, 16'd2);
    chk("R4 four levels no ovf", stk_ovf, 0);
    step(OP_LOOP, 0, 16'd500, 16'd2);
    chk("R6 fifth loop ovf", stk_ovf, 1);

    // R7/R8 interrupts
    do_reset();
    irq_en = 10'b0010100000;          // sources 5 and 7
    idle(); idle();
    irq_req = 10'b0010100100;         // sources 2, 5, 7
    idle();
    chk("R7 latched pc", pc, 3);
    chk("R7 ack", irq_ack, 1);
    chk("R7 lowest enabled id", irq_id, 5);
    step(OP_JMP, 16'd200, 0, 0);      // preempted strobe
    chk("R7 vector 5", pc, vec(5));
    chk("R7 next ack id", irq_id, 7);
    idle();
    chk("R7 vector 7", pc, vec(7));
    chk("R8 masked not taken", irq_ack, 0);
    step(OP_RET, 0, 0, 0); chk("R7 ret to vector 5", pc, vec(5));
    step(OP_RET, 0, 0, 0); chk("R7 ret to preempted", pc, 3);
    idle();
    chk("R8 still not taken", irq_ack, 0);
    irq_en = 10'b0010100100;
    #1;
    chk("R8 taken once enabled", irq_ack, 1);
    chk("R8 id", irq_id, 2);
    idle();
    chk("R8 vector 2", pc, vec(2));

    // R9/R10 halt and wake
    do_reset();
    irq_en = 10'b0000001000;          // source 3 only
    step(OP_HALT, 0, 0, 0);
    chk("R9 sleep", sleep, 1);
    chk("R9 no fetch", fetch_en, 0);
    chk("R9 pc next", pc, 1);
    step(OP_JMP, 16'd77, 0, 0);
    chk("R9 pc parked", pc, 1);
    irq_req = 10'b0100000000;         // disabled source 8
    idle(); idle();
    chk("R9 disabled keeps sleep", sleep, 1);
    irq_req = 10'b0000001000;
    idle();
    chk("R9 sleep until pending", sleep, 1);
    idle();
    chk("R10 sleep fell", sleep, 0);
    chk("R10 fetch low 1", fetch_en, 0);
    idle(); chk("R10 fetch low 2", fetch_en, 0);
    idle(); chk("R10 fetch low 3", fetch_en, 0);
    idle(); chk("R10 fetch low 4", fetch_en, 0);
    idle();
    chk("R10 fetch resumes", fetch_en, 1);
    chk("R10 wake irq ack", irq_ack, 1);
    chk("R10 wake irq id", irq_id, 3);
    chk("R9 pc on resume", pc, 1);

    finish_run();
  end
endmodule